// File: doc/BRIEF.md
# Oversample-and-Decimate Resolution Enhancer

This block raises the effective resolution of a 12-bit converter by gathering a burst of consecutive conversions and folding them into one wider word. A periodic tick from a sampling-period timer opens each burst. While the burst is open, every conversion that arrives with its valid flag set is added into a running sum. For `p` extra bits the burst holds 4^p conversions. Once the last one is in, the sum is shifted right by `p`. The result is therefore 12+p bits of useful data and is not scaled back to the input width. With `p = 1` a steady code of 1250 reads 2500, and with `p = 2` it reads 5000.

The number of extra bits comes from a configuration input that is captured when each burst starts, so the setting can be changed at any time without disturbing a burst in flight. The sampling tick must be slower than one full burst. A tick that arrives while a burst is still collecting does not restart the burst. Instead it sets a flag that stays set until reset.

Top module: `oversample_decimator`

## Requirements
- R1: After reset, `res_data` is 0 and `res_valid`, `overrun` and `busy` are all 0.
- R2: A `period_tick` sampled high while `busy` is 0 clears the running sum and sets `busy` at that same clock edge. Conversions are accepted from the following edge onward.
- R3: A conversion is added only at an edge where both `smp_valid` and `busy` are 1. Data presented while `smp_valid` is 0, or while the block is idle, has no effect on any result.
- R4: A burst ends after exactly 4^p accepted conversions. `p` is the value of `extra_bits` captured at the starting tick, and codes 5 to 7 are treated as 4.
- R5: At the edge that accepts the last conversion of a burst, three things happen together: `res_data` takes the value (sum of the burst's conversions) >> p, zero-extended to 16 bits; `res_valid` is 1 for exactly that one cycle; and `busy` returns to 0.
- R6: `res_data` keeps its value in every cycle in which `res_valid` is 0.
- R7: A `period_tick` sampled while `busy` is 1 is ignored, so the burst in progress keeps its count and sum. The same tick sets `overrun`, which stays 1 until reset.
- R8: Changing `extra_bits` while a burst is collecting does not change that burst's length or shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_tick | input | 1 | Sampling-period tick that opens a burst |
| extra_bits | input | 3 | Requested extra resolution bits p (0 to 4, larger values clamp to 4) |
| smp_valid | input | 1 | Conversion present on `smp_data` |
| smp_data | input | 12 | Converter output code |
| res_data | output | 16 | Enhanced-resolution result, held until replaced |
| res_valid | output | 1 | One-cycle strobe marking a new result |
| overrun | output | 1 | Sticky flag: a tick arrived while a burst was open |
| busy | output | 1 | A burst is collecting conversions |

## Verification
A tick at edge k raises `busy` at edge k and makes conversions acceptable from edge k+1. The result and its strobe appear at the same edge that takes in the final conversion, so after its last sample the bench waits exactly one edge and reads `res_data`, `res_valid` and `busy` at the following falling edge. The bench drives all inputs and samples all outputs on falling edges, so each check falls in the single cycle where the value is due. For the hold and sticky-flag checks, the bench idles a fixed number of cycles and then confirms the values are unchanged.

// File: rtl/ovs_pkg.sv
package ovs_pkg;

    typedef enum logic {
        BURST_IDLE = 1'b0,
        BURST_RUN  = 1'b1
    } burst_state_e;

endpackage

// File: rtl/ovs_sequencer.sv
module ovs_sequencer
    import ovs_pkg::*;
#(
    parameter int MAX_EXTRA = 4,
    parameter int P_W       = 3,
    parameter int CNT_W     = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           period_tick,
    input  logic [P_W-1:0] extra_bits,
    input  logic           smp_valid,
    output logic           start,
    output logic           accept,
    output logic           last,
    output logic [P_W-1:0] shift_amt,
    output logic           busy,
    output logic           overrun
);

    typedef struct packed {
        burst_state_e   state;
        logic [CNT_W-1:0] cnt;
        logic [P_W-1:0] p;
        logic           ovr;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [P_W-1:0]   p_sel;
    logic [CNT_W-1:0] cnt_final;

    always_comb begin
        // clamp request to the supported range
        p_sel = (extra_bits > P_W'(MAX_EXTRA)) ? P_W'(MAX_EXTRA) : extra_bits;
        // index of the final sample: 4^p - 1
        cnt_final = {CNT_W{1'b1}} >> (2 * (MAX_EXTRA - int'(seq_q.p)));

        start  = period_tick && (seq_q.state == BURST_IDLE);
        accept = smp_valid && (seq_q.state == BURST_RUN);
        last   = accept && (seq_q.cnt == cnt_final);

        seq_d = seq_q;
        if (period_tick && (seq_q.state == BURST_RUN)) begin
            seq_d.ovr = 1'b1;
        end
        if (start) begin
            seq_d.state = BURST_RUN;
            seq_d.cnt   = '0;
            seq_d.p     = p_sel;
        end else if (last) begin
            seq_d.state = BURST_IDLE;
            seq_d.cnt   = '0;
        end else if (accept) begin
            seq_d.cnt = seq_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{state: BURST_IDLE, cnt: '0, p: '0, ovr: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign shift_amt = seq_q.p;
    assign busy      = (seq_q.state == BURST_RUN);
    assign overrun   = seq_q.ovr;

endmodule

// File: rtl/ovs_accumulator.sv
module ovs_accumulator #(
    parameter int SAMPLE_W = 12,
    parameter int ACC_W    = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                accept,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [ACC_W-1:0]    sum_next
);

    logic [ACC_W-1:0] acc_d, acc_q;

    always_comb begin
        sum_next = acc_q + ACC_W'(sample);
        acc_d    = acc_q;
        if (clear) begin
            acc_d = '0;
        end else if (accept) begin
            acc_d = sum_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

endmodule

// File: rtl/ovs_shifter.sv
module ovs_shifter #(
    parameter int ACC_W = 20,
    parameter int OUT_W = 16,
    parameter int P_W   = 3
) (
    input  logic [ACC_W-1:0] sum,
    input  logic [P_W-1:0]   shift_amt,
    output logic [OUT_W-1:0] result
);

    logic [ACC_W-1:0] shifted;

    always_comb begin
        shifted = sum >> shift_amt;
        result  = shifted[OUT_W-1:0];
    end

endmodule

// File: rtl/oversample_decimator.sv
module oversample_decimator #(
    parameter int SAMPLE_W  = 12,
    parameter int MAX_EXTRA = 4,
    parameter int P_W       = $clog2(MAX_EXTRA + 1),
    parameter int OUT_W     = SAMPLE_W + MAX_EXTRA
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                period_tick,
    input  logic [P_W-1:0]      extra_bits,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic [OUT_W-1:0]    res_data,
    output logic                res_valid,
    output logic                overrun,
    output logic                busy
);

    localparam int ACC_W = SAMPLE_W + 2 * MAX_EXTRA;
    localparam int CNT_W = (2 * MAX_EXTRA > 0) ? 2 * MAX_EXTRA : 1;

    typedef struct packed {
        logic [OUT_W-1:0] data;
        logic             valid;
    } res_t;

    res_t res_d, res_q;

    logic             start, accept, last;
    logic [P_W-1:0]   shift_amt;
    logic [ACC_W-1:0] sum_next;
    logic [OUT_W-1:0] shifted;

    ovs_sequencer #(
        .MAX_EXTRA (MAX_EXTRA),
        .P_W       (P_W),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .period_tick (period_tick),
        .extra_bits  (extra_bits),
        .smp_valid   (smp_valid),
        .start       (start),
        .accept      (accept),
        .last        (last),
        .shift_amt   (shift_amt),
        .busy        (busy),
        .overrun     (overrun)
    );

    ovs_accumulator #(
        .SAMPLE_W (SAMPLE_W),
        .ACC_W    (ACC_W)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start),
        .accept   (accept),
        .sample   (smp_data),
        .sum_next (sum_next)
    );

    ovs_shifter #(
        .ACC_W (ACC_W),
        .OUT_W (OUT_W),
        .P_W   (P_W)
    ) u_shf (
        .sum       (sum_next),
        .shift_amt (shift_amt),
        .result    (shifted)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = 1'b0;
        if (last) begin
            res_d.data  = shifted;
            res_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '{data: '0, valid: 1'b0};
        end else begin
            res_q <= res_d;
        end
    end

    assign res_data  = res_q.data;
    assign res_valid = res_q.valid;

endmodule

// File: rtl/ovs_checker.sv
module ovs_checker #(
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             period_tick,
    input logic             busy,
    input logic             res_valid,
    input logic [OUT_W-1:0] res_data,
    input logic             overrun
);

    // R2
    tick_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_tick && !busy) |=> busy);

    // R5
    end_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> res_valid);

    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R6
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> $stable(res_data));

    // R7
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_tick && busy) |=> overrun);

    // R7
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

endmodule

bind oversample_decimator ovs_checker #(.OUT_W(OUT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .period_tick (period_tick),
    .busy        (busy),
    .res_valid   (res_valid),
    .res_data    (res_data),
    .overrun     (overrun)
);

// File: tb/sim_oversample_decimator.sv
`timescale 1ns/1ps
module sim_oversample_decimator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        period_tick = 1'b0;
    logic [2:0]  extra_bits = 3'd0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_data = 12'd0;
    logic [15:0] res_data;
    logic        res_valid;
    logic        overrun;
    logic        busy;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    oversample_decimator u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .period_tick (period_tick),
        .extra_bits  (extra_bits),
        .smp_valid   (smp_valid),
        .smp_data    (smp_data),
        .res_data    (res_data),
        .res_valid   (res_valid),
        .overrun     (overrun),
        .busy        (busy)
    );

    typedef struct packed {
        logic [2:0]  p;
        logic [11:0] base;
        logic [11:0] step;
        logic        gap;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{p: 3'd1, base: 12'd1250, step: 12'd0,   gap: 1'b0},
        '{p: 3'd2, base: 12'd1250, step: 12'd0,   gap: 1'b0},
        '{p: 3'd0, base: 12'd100,  step: 12'd0,   gap: 1'b0},
        '{p: 3'd3, base: 12'd4000, step: 12'd7,   gap: 1'b1},
        '{p: 3'd4, base: 12'd4095, step: 12'd0,   gap: 1'b0},
        '{p: 3'd2, base: 12'd0,    step: 12'd1,   gap: 1'b1},
        '{p: 3'd1, base: 12'd2047, step: 12'd1,   gap: 1'b0},
        '{p: 3'd3, base: 12'd10,   step: 12'd300, gap: 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one burst. tick_at >= 0 raises a spurious tick with that sample;
    // p_mid_change alters extra_bits after the second sample.
    task automatic burst(input string req, input logic [2:0] p_cfg, input logic [11:0] base,
                         input logic [11:0] step, input logic gap, input int tick_at,
                         input logic p_mid_change);
        int eff_p;
        int n;
        longint sum;
        logic [11:0] s;
        eff_p = (p_cfg > 3'd4) ? 4 : int'(p_cfg);
        n = 1 << (2 * eff_p);
        sum = 0;
        @(negedge clk);
        period_tick = 1'b1;
        extra_bits  = p_cfg;
        @(negedge clk);
        period_tick = 1'b0;
        for (int i = 0; i < n; i++) begin
            s = 12'(int'(base) + i * int'(step));
            if (gap) begin
                smp_valid = 1'b0;
                smp_data  = 12'hABC;
                @(negedge clk);
            end
            smp_valid = 1'b1;
            smp_data  = s;
            period_tick = (i == tick_at);
            if (p_mid_change && i == 1) extra_bits = 3'd0;
            @(negedge clk);
            period_tick = 1'b0;
            sum += s;
            if (i == n - 2) check({req, " busy before last sample"}, 32'(busy), 32'd1);
        end
        smp_valid = 1'b0;
        check({req, " res_valid"}, 32'(res_valid), 32'd1);
        check({req, " res_data"}, 32'(res_data), 32'(sum >> eff_p));
        check({req, " busy cleared"}, 32'(busy), 32'd0);
    endtask

    initial begin : watchdog
        while (cyc < 150000) @(posedge clk) cyc++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 res_data", 32'(res_data), 0);
        check("R1 res_valid", 32'(res_valid), 0);
        check("R1 overrun", 32'(overrun), 0);
        check("R1 busy", 32'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 R5 R3 table walk (gap entries exercise R3)
        foreach (VECS[k]) begin
            burst($sformatf("R5 vec%0d", k), VECS[k].p, VECS[k].base, VECS[k].step,
                  VECS[k].gap, -1, 1'b0);
        end

        // R6 result held, strobe single-cycle
        held = res_data;
        repeat (5) @(negedge clk);
        check("R6 res_data held", 32'(res_data), 32'(held));
        check("R5 res_valid pulse width", 32'(res_valid), 0);

        // R3 samples while idle ignored, R2 start needs a tick
        smp_valid = 1'b1;
        smp_data  = 12'd4000;
        repeat (3) @(negedge clk);
        smp_valid = 1'b0;
        check("R2 no burst without tick", 32'(busy), 0);
        check("R3 idle samples no result", 32'(res_valid), 0);
        burst("R3 idle then p0", 3'd0, 12'd33, 12'd0, 1'b0, -1, 1'b0);

        // R2 busy one edge after tick
        @(negedge clk);
        period_tick = 1'b1;
        extra_bits  = 3'd1;
        @(negedge clk);
        period_tick = 1'b0;
        check("R2 busy after tick", 32'(busy), 1);
        for (int i = 0; i < 4; i++) begin
            smp_valid = 1'b1;
            smp_data  = 12'(500 + i);
            @(negedge clk);
        end
        smp_valid = 1'b0;
        check("R2 sum cleared at start", 32'(res_data), 32'((500 + 501 + 502 + 503) >> 1));

        // R4 clamp: code 7 behaves as 4
        burst("R4 clamp", 3'd7, 12'd3, 12'd5, 1'b0, -1, 1'b0);

        // R8 extra_bits change mid-burst
        burst("R8 mid change", 3'd2, 12'd900, 12'd3, 1'b0, -1, 1'b1);

        check("R7 overrun clear before", 32'(overrun), 0);
        // R7 tick while busy ignored, overrun sticky
        burst("R7 tick in burst", 3'd1, 12'd1000, 12'd11, 1'b0, 1, 1'b0);
        check("R7 overrun set", 32'(overrun), 1);
        repeat (4) @(negedge clk);
        check("R7 no restart after tick", 32'(busy), 0);
        burst("R7 after overrun", 3'd1, 12'd20, 12'd2, 1'b0, -1, 1'b0);
        check("R7 overrun sticky", 32'(overrun), 1);

        // R1 reset clears flag and result
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset overrun", 32'(overrun), 0);
        check("R1 reset res_data", 32'(res_data), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule